// File: doc/BRIEF.md
# Seven-Step Permuted Code Sequencer

This block is a free-running Moore machine that steps a 3-bit code through a fixed cycle of seven values in the order 0, 3, 2, 4, 1, 5, 7, then back to 0. Apart from the clock and a synchronous reset it takes no inputs. The output is the state register itself, so each value holds for one full clock period and changes only at a rising edge.

Code 6 is never part of the cycle. If the register ever holds 6, the next edge moves it to 0, and the machine is back in the cycle within one clock.

A parameter selects how the next-state logic is built. One option is a case table and the other is hand-reduced sum-of-products equations; both give the same behaviour. A second parameter sets the code loaded on reset, which is 0 by default.

Top module: `seq7_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the output is loaded with INIT_CODE (default 0) at that edge and holds that value for as long as reset stays high.
- R2: After reset is released from code 0, successive rising edges produce the codes 3, 2, 4, 1, 5, 7 in that order.
- R3: From code 7 the next edge produces 0, so the cycle repeats with a period of exactly seven clocks.
- R4: If the state holds code 6, which is unused, the next edge produces 0.
- R5: The output changes only at rising clock edges and stays stable between them.
- R6: The table-based next-state variant (NEXT_IMPL = IMPL_TABLE) and the equation-based variant (NEXT_IMPL = IMPL_EQN) produce identical sequences.
- R7: Reset is synchronous. Raising `rst` between edges leaves the output unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge advances the sequence one step |
| rst | input | 1 | Synchronous active-high reset, loads INIT_CODE |
| seq_value | output | 3 | Present state, which is also the output code |

## Verification
The checker assumes that `rst` is the only control input, that it is sampled only at rising edges, and that it may be held high for any number of cycles. It makes no assumption about which code the state starts from, so the recovery property for code 6 also covers a reset value of 6. The stimulus changes `rst` only at falling edges. A second instance with INIT_CODE = 6 and the equation variant makes the illegal code reachable through the normal reset path.

// File: rtl/seq7_pkg.sv
package seq7_pkg;

    localparam int CODE_W    = 3;
    localparam int CYCLE_LEN = 7;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        IMPL_TABLE = 1'b0,
        IMPL_EQN   = 1'b1
    } impl_e;

    localparam code_t SKIP_CODE = code_t'(6);

    // Successor of a code in the permuted cycle; the unused code returns to 0.
    function automatic code_t step_of(input code_t cur);
        code_t nxt;
        case (cur)
            code_t'(0): nxt = code_t'(3);
            code_t'(3): nxt = code_t'(2);
            code_t'(2): nxt = code_t'(4);
            code_t'(4): nxt = code_t'(1);
            code_t'(1): nxt = code_t'(5);
            code_t'(5): nxt = code_t'(7);
            code_t'(7): nxt = code_t'(0);
            default:    nxt = code_t'(0);
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/seq7_next.sv
module seq7_next
    import seq7_pkg::*;
#(
    parameter impl_e NEXT_IMPL = IMPL_TABLE
) (
    input  code_t cur_code,
    output code_t nxt_code
);

    generate
        if (NEXT_IMPL == IMPL_TABLE) begin : g_table
            always_comb nxt_code = step_of(cur_code);
        end else begin : g_eqn
            logic b2, b1, b0;
            always_comb begin
                b2 = cur_code[2];
                b1 = cur_code[1];
                b0 = cur_code[0];
                nxt_code[2] = (~b1 & b0) | (~b2 & b1 & ~b0);
                nxt_code[1] = (~b2 & ~b1 & ~b0) | (~b2 & b1 & b0) | (b2 & ~b1 & b0);
                nxt_code[0] = ~b1;
            end
        end
    endgenerate

endmodule

// File: rtl/seq7_state.sv
module seq7_state
    import seq7_pkg::*;
#(
    parameter code_t INIT_CODE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t d_code,
    output code_t q_code
);

    always_ff @(posedge clk) begin
        if (rst) q_code <= INIT_CODE;
        else     q_code <= d_code;
    end

endmodule

// File: rtl/seq7_gen.sv
module seq7_gen
    import seq7_pkg::*;
#(
    parameter impl_e NEXT_IMPL = IMPL_TABLE,
    parameter code_t INIT_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CODE_W-1:0] seq_value
);

    code_t state_q;
    code_t state_d;

    seq7_next #(.NEXT_IMPL(NEXT_IMPL)) u_next (
        .cur_code (state_q),
        .nxt_code (state_d)
    );

    seq7_state #(.INIT_CODE(INIT_CODE)) u_state (
        .clk    (clk),
        .rst    (rst),
        .d_code (state_d),
        .q_code (state_q)
    );

    assign seq_value = state_q;

endmodule

// File: rtl/seq7_gen_chk.sv
module seq7_gen_chk
    import seq7_pkg::*;
#(
    parameter code_t INIT_CODE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] seq_value
);

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> seq_value == INIT_CODE);

    assert_zero_to_three_R2: assert property (@(posedge clk) disable iff (rst)
        seq_value == 3'd0 |=> seq_value == 3'd3);

    assert_five_to_seven_R2: assert property (@(posedge clk) disable iff (rst)
        seq_value == 3'd5 |=> seq_value == 3'd7);

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
        seq_value == 3'd7 |=> seq_value == 3'd0);

    assert_skip_recovers_R4: assert property (@(posedge clk) disable iff (rst)
        seq_value == SKIP_CODE |=> seq_value == 3'd0);

endmodule

bind seq7_gen seq7_gen_chk #(.INIT_CODE(INIT_CODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seq_value (seq_value)
);

// File: tb/sim_seq7_gen.sv
module sim_seq7_gen;
    import seq7_pkg::*;

    localparam int PERIOD = 10;
    localparam int NSTEP  = 16;
    localparam logic [2:0] EXP [NSTEP] = '{
        3'd0, 3'd3, 3'd2, 3'd4, 3'd1, 3'd5, 3'd7, 3'd0,
        3'd3, 3'd2, 3'd4, 3'd1, 3'd5, 3'd7, 3'd0, 3'd3
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] val0, val1, held;
    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    seq7_gen u0 (.clk(clk), .rst(rst), .seq_value(val0));
    seq7_gen #(.NEXT_IMPL(IMPL_EQN), .INIT_CODE(3'd6)) u1 (
        .clk(clk), .rst(rst), .seq_value(val1));

    task automatic check(input logic [2:0] got, input logic [2:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    initial begin
        #(PERIOD * 2000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset held for several edges
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(val0, 3'd0, "R1 reset u0");
        check(val1, 3'd6, "R1 reset u1");
        @(negedge clk);
        check(val0, 3'd0, "R1 reset hold u0");
        rst = 1'b0;

        // R2 R3 R6 R4: walk the vector table
        for (int i = 1; i < NSTEP; i++) begin
            @(posedge clk);
            #1 held = val0;
            @(negedge clk);
            check(val0, EXP[i], (i % 7 == 0) ? "R3 wrap u0" : "R2 step u0");
            check(val0, held, "R5 stable between edges");
            check(val1, EXP[i-1], (i == 1) ? "R4 skip code recovers" : "R6 eqn variant");
        end

        // R7: reset raised between edges takes effect only at the edge
        held = val0;
        rst  = 1'b1;
        #1 check(val0, held, "R7 sync reset no immediate effect");
        @(posedge clk);
        @(negedge clk);
        check(val0, 3'd0, "R1 mid-run reset u0");
        check(val1, 3'd6, "R1 mid-run reset u1");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(val0, 3'd3, "R2 restart u0");
        check(val1, 3'd0, "R4 second recovery");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule